// File: doc/BRIEF.md
# Sleep Control Register for Power Management

This block holds a 16-bit power-management control word on a small byte/word I/O bus and turns a software request to enter a sleep state into hardware actions. Software writes either one byte, to the low or the high half, or a whole 16-bit word. The sleep-type field and the sleep-enable trigger sit in the high byte. When a write that carries the high byte has sleep-enable set, the block decodes the sleep type. A suspend-to-RAM request (S3) produces a one-cycle system reset pulse, sets a sticky resume flag and reports sleep state 3. A hibernate (S4) or soft-off (S5) request produces a one-cycle shutdown request.

Reads return the stored word with the write-only bits forced to zero. The sleep-enable bit is never stored. It acts only as a trigger on the write that carries it. The register answers at offset 4 from a power-management I/O base, which defaults to 0x1F40. The low byte is at base+4 and the high byte is at base+5.

Top module: `pm_sleep_ctl`

## Requirements
- R1: After reset the register reads 0x0001 (SCI-enable, bit 0, set and all other bits clear). `sys_reset_pulse`, `shutdown_req` and `s3_resume` are low, and `sleep_state` is 0.
- R2: A read at base+4 returns the full word, and a read at base+5 returns bits 15:8 in `io_rdata[7:0]`. In both cases global-lock-release (bit 2) and sleep-enable (bit 13) read as zero. Any other address reads zero.
- R3: Sleep-enable (bit 13) is cleared before any write is stored, so it never reads back set, even through the high-byte view.
- R4: A byte write (`io_word`=0) at base+4 stores `io_wdata[7:0]` into bits 7:0. It leaves bits 15:8 unchanged and never causes a sleep action.
- R5: A byte write at base+5 stores `io_wdata[7:0]` into bits 15:8 and keeps bits 7:0. The sleep fields are taken from that written byte.
- R6: A word write (`io_word`=1) at base+4 replaces all 16 bits, except that bit 13 is cleared, and evaluates the sleep fields.
- R7: A sleep-evaluating write with bit 13 set and sleep type (bits 12:10) equal to 5 drives `sys_reset_pulse` high for exactly the one cycle after the write strobe. The same write sets `s3_resume`, which then stays set until `rst_n`, and sets `sleep_state` to 3.
- R8: A sleep-evaluating write with bit 13 set and sleep type 6 or 7 drives `shutdown_req` high for exactly the one cycle after the write strobe. It does not pulse `sys_reset_pulse`.
- R9: A sleep-evaluating write with bit 13 clear, or with any sleep type other than 5, 6 or 7, produces no pulse.
- R10: Writes to any address other than base+4 and base+5 are ignored. A word write at base+5 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_word | input | 1 | 1 = 16-bit word access, 0 = byte access |
| io_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| io_rdata | output | 16 | Read data for the current address, masked |
| sys_reset_pulse | output | 1 | One-cycle system reset pulse on S3 entry |
| s3_resume | output | 1 | Sticky S3-resume flag |
| sleep_state | output | 3 | Reported sleep state (0 or 3) |
| shutdown_req | output | 1 | One-cycle shutdown request on S4/S5 |

## Verification
The bench builds the block with the default base of 0x1F40 and a 16-bit address. With these values, near-miss addresses such as base+0, base+6 and a base that differs in its upper bits can be hit directly. Under these parameters every sleep type reaches the decoder through both the high-byte and the word path. Running S3 twice shows that the resume flag stays set, and that a low-byte write carrying a set bit 13 in its upper data lane has no effect.

// File: rtl/pm_sleep_pkg.sv
package pm_sleep_pkg;
  localparam int unsigned CTL_W       = 16;
  localparam int unsigned LANES       = CTL_W / 8;
  localparam int unsigned SCI_EN_POS  = 0;
  localparam int unsigned GLB_REL_POS = 2;
  localparam int unsigned SLP_EN_POS  = 13;
  localparam int unsigned SLP_TYP_LSB = 10;
  localparam int unsigned SLP_TYP_W   = 3;

  localparam logic [SLP_TYP_W-1:0] TYP_SUSPEND   = 3'd5;
  localparam logic [SLP_TYP_W-1:0] TYP_HIBERNATE = 3'd6;
  localparam logic [SLP_TYP_W-1:0] TYP_SOFT_OFF  = 3'd7;
  localparam logic [2:0]           STATE_S3      = 3'd3;

  typedef enum logic [1:0] {
    ACT_NONE      = 2'd0,
    ACT_SUSPEND   = 2'd1,
    ACT_POWER_OFF = 2'd2
  } sleep_act_e;
endpackage

// File: rtl/pm_bus_decode.sv
module pm_bus_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned PM_BASE = 32'h1F40,
  parameter int unsigned REG_OFS = 4,
  parameter int unsigned LANES   = 2
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_word,
  output logic [LANES-1:0]  lane_we,
  output logic [LANES-1:0]  rd_hit,
  output logic              eval_sleep
);
  localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(PM_BASE + REG_OFS);

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      assign rd_hit[l]  = (io_addr == REG_ADDR + ADDR_W'(l));
      // word accesses are accepted only at the aligned address
      assign lane_we[l] = io_wr & (io_word ? (io_addr == REG_ADDR) : rd_hit[l]);
    end
  endgenerate

  // the sleep fields live in the top lane
  assign eval_sleep = lane_we[LANES-1];
endmodule

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg
  import pm_sleep_pkg::*;
#(
  parameter int unsigned NLANES = LANES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NLANES-1:0]     lane_we,
  input  logic                  io_word,
  input  logic [8*NLANES-1:0]   io_wdata,
  output logic [8*NLANES-1:0]   ctl_q,
  output logic [8*NLANES-1:0]   rd_view,
  output logic                  wr_slp_en,
  output logic [SLP_TYP_W-1:0]  wr_slp_typ
);
  localparam int unsigned W = 8 * NLANES;
  localparam logic [W-1:0] RESET_VAL = W'(1) << SCI_EN_POS;
  localparam logic [W-1:0] RD_MASK   = (W'(1) << SLP_EN_POS) | (W'(1) << GLB_REL_POS);

  logic [W-1:0] lane_wd;
  logic [W-1:0] merged;
  logic [W-1:0] ctl_d;
  logic         ctl_en;

  genvar l;
  generate
    for (l = 0; l < NLANES; l++) begin : g_lane
      assign lane_wd[l*8 +: 8] = io_word ? io_wdata[l*8 +: 8] : io_wdata[7:0];
      assign merged[l*8 +: 8]  = lane_we[l] ? lane_wd[l*8 +: 8] : ctl_q[l*8 +: 8];
    end
  endgenerate

  always_comb begin
    ctl_d             = merged;
    ctl_d[SLP_EN_POS] = 1'b0;
  end

  assign ctl_en = |lane_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= RESET_VAL;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign rd_view    = ctl_q & ~RD_MASK;
  assign wr_slp_en  = lane_wd[SLP_EN_POS];
  assign wr_slp_typ = lane_wd[SLP_TYP_LSB +: SLP_TYP_W];
endmodule

// File: rtl/pm_sleep_decode.sv
module pm_sleep_decode
  import pm_sleep_pkg::*;
(
  input  logic                 eval_sleep,
  input  logic                 wr_slp_en,
  input  logic [SLP_TYP_W-1:0] wr_slp_typ,
  output sleep_act_e           act
);
  always_comb begin
    act = ACT_NONE;
    if (eval_sleep && wr_slp_en) begin
      unique case (wr_slp_typ)
        TYP_SUSPEND:                 act = ACT_SUSPEND;
        TYP_HIBERNATE, TYP_SOFT_OFF: act = ACT_POWER_OFF;
        default:                     act = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pm_action_out.sv
module pm_action_out
  import pm_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sleep_act_e act,
  output logic       sys_reset_pulse,
  output logic       s3_resume,
  output logic [2:0] sleep_state,
  output logic       shutdown_req
);
  logic       rst_pulse_d, shd_d, resume_d;
  logic [2:0] state_d;

  always_comb begin
    rst_pulse_d = (act == ACT_SUSPEND);
    shd_d       = (act == ACT_POWER_OFF);
    resume_d    = s3_resume | (act == ACT_SUSPEND);
    state_d     = (act == ACT_SUSPEND) ? STATE_S3 : sleep_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_reset_pulse <= 1'b0;
      shutdown_req    <= 1'b0;
      s3_resume       <= 1'b0;
      sleep_state     <= 3'd0;
    end else begin
      sys_reset_pulse <= rst_pulse_d;
      shutdown_req    <= shd_d;
      s3_resume       <= resume_d;
      sleep_state     <= state_d;
    end
  end
endmodule

// File: rtl/pm_sleep_ctl.sv
module pm_sleep_ctl
  import pm_sleep_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned PM_BASE = 32'h1F40,
  parameter int unsigned REG_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_word,
  input  logic [CTL_W-1:0]  io_wdata,
  output logic [CTL_W-1:0]  io_rdata,
  output logic              sys_reset_pulse,
  output logic              s3_resume,
  output logic [2:0]        sleep_state,
  output logic              shutdown_req
);
  logic [LANES-1:0]     lane_we;
  logic [LANES-1:0]     rd_hit;
  logic                 eval_sleep;
  logic [CTL_W-1:0]     rd_view;
  logic                 wr_slp_en;
  logic [SLP_TYP_W-1:0] wr_slp_typ;
  sleep_act_e           act;

  pm_bus_decode #(
    .ADDR_W(ADDR_W), .PM_BASE(PM_BASE), .REG_OFS(REG_OFS), .LANES(LANES)
  ) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_word(io_word),
    .lane_we(lane_we), .rd_hit(rd_hit), .eval_sleep(eval_sleep)
  );

  pm_ctl_reg #(.NLANES(LANES)) u_reg (
    .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .io_word(io_word),
    .io_wdata(io_wdata), .ctl_q(), .rd_view(rd_view),
    .wr_slp_en(wr_slp_en), .wr_slp_typ(wr_slp_typ)
  );

  pm_sleep_decode u_sdec (
    .eval_sleep(eval_sleep), .wr_slp_en(wr_slp_en),
    .wr_slp_typ(wr_slp_typ), .act(act)
  );

  pm_action_out u_act (
    .clk(clk), .rst_n(rst_n), .act(act),
    .sys_reset_pulse(sys_reset_pulse), .s3_resume(s3_resume),
    .sleep_state(sleep_state), .shutdown_req(shutdown_req)
  );

  // byte lane l is returned right-aligned
  always_comb begin
    io_rdata = '0;
    for (int l = 0; l < int'(LANES); l++) begin
      if (rd_hit[l]) io_rdata = rd_view >> (8 * l);
    end
  end
endmodule

// File: rtl/pm_sleep_ctl_chk.sv
module pm_sleep_ctl_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned PM_BASE = 32'h1F40,
  parameter int unsigned REG_OFS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_word,
  input logic              wr_se,
  input logic [15:0]       ctl_q,
  input logic              sys_reset_pulse,
  input logic              s3_resume,
  input logic [2:0]        sleep_state,
  input logic              shutdown_req
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(PM_BASE + REG_OFS);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(PM_BASE + REG_OFS + 1);

  p_se_not_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[13]);

  p_low_byte_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_word && io_addr == A_LO) |=> (!sys_reset_pulse && !shutdown_req));

  p_s3_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_pulse |-> (s3_resume && sleep_state == 3'd3));

  p_resume_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s3_resume |=> s3_resume);

  p_pulse_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_reset_pulse || shutdown_req) |-> $past(io_wr));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_reset_pulse && shutdown_req));

  p_no_se_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_word && io_addr == A_LO && !wr_se) |=> (!sys_reset_pulse && !shutdown_req));

  p_foreign_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != A_LO && io_addr != A_HI) |=> $stable(ctl_q));
endmodule

bind pm_sleep_ctl pm_sleep_ctl_chk #(
  .ADDR_W(ADDR_W), .PM_BASE(PM_BASE), .REG_OFS(REG_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
  .io_word(io_word), .wr_se(io_wdata[13]), .ctl_q(u_reg.ctl_q),
  .sys_reset_pulse(sys_reset_pulse), .s3_resume(s3_resume),
  .sleep_state(sleep_state), .shutdown_req(shutdown_req)
);

// File: tb/pm_sleep_ctl_tb_top.sv
module pm_sleep_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_LO = 16'h1F44;
  localparam logic [15:0] A_HI = 16'h1F45;
  localparam logic [15:0] RMASK = 16'h2004;

  logic        clk, rst_n;
  logic [15:0] io_addr;
  logic        io_wr, io_word;
  logic [15:0] io_wdata;
  logic [15:0] io_rdata;
  logic        sys_reset_pulse, s3_resume, shutdown_req;
  logic [2:0]  sleep_state;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;
  bit mon_on   = 0;
  string cur_req = "R1";

  pm_sleep_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_word(io_word), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .sys_reset_pulse(sys_reset_pulse), .s3_resume(s3_resume),
    .sleep_state(sleep_state), .shutdown_req(shutdown_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [15:0] m_reg;
  bit          m_rst, m_shd, m_flag;
  int          m_state;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 16'h0001; m_rst = 0; m_shd = 0; m_flag = 0; m_state = 0;
    end else begin
      logic [15:0] img;
      bit ev;
      m_rst = 0; m_shd = 0; ev = 0; img = 16'h0;
      if (io_wr) begin
        if (io_word && io_addr == A_LO) begin
          img = io_wdata; m_reg = io_wdata; ev = 1;
        end else if (!io_word && io_addr == A_LO) begin
          m_reg[7:0] = io_wdata[7:0];
        end else if (!io_word && io_addr == A_HI) begin
          img = {io_wdata[7:0], 8'h00}; m_reg[15:8] = io_wdata[7:0]; ev = 1;
        end
        m_reg[13] = 1'b0;
        if (ev && img[13]) begin
          case (img[12:10])
            3'd5: begin m_rst = 1; m_flag = 1; m_state = 3; end
            3'd6, 3'd7: m_shd = 1;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [15:0] exp_read(logic [15:0] a);
    if (a == A_LO) return m_reg & ~RMASK;
    if (a == A_HI) return (m_reg & ~RMASK) >> 8;
    return 16'h0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && mon_on && !done) begin
      chk(io_rdata == exp_read(io_addr), cur_req, "model rdata", io_rdata, exp_read(io_addr));
      chk(sys_reset_pulse == m_rst, cur_req, "model reset pulse", sys_reset_pulse, m_rst);
      chk(shutdown_req == m_shd, cur_req, "model shutdown", shutdown_req, m_shd);
      chk(s3_resume == m_flag, cur_req, "model resume", s3_resume, m_flag);
      chk(int'(sleep_state) == m_state, cur_req, "model state", sleep_state, m_state);
    end
  end

  task automatic wr(logic [15:0] a, bit w, logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_word = w; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = A_LO; io_word = 1'b0; io_wdata = 16'h0;
    #1;
  endtask

  task automatic expect_out(string req, logic [15:0] rd, bit rp, bit sd);
    chk(io_rdata == rd, req, "rdata", io_rdata, rd);
    chk(sys_reset_pulse == rp, req, "reset pulse", sys_reset_pulse, rp);
    chk(shutdown_req == sd, req, "shutdown", shutdown_req, sd);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; io_addr = A_LO; io_wr = 1'b0; io_word = 1'b0; io_wdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    mon_on = 1;

    cur_req = "R1";
    expect_out("R1", 16'h0001, 0, 0);
    chk(s3_resume == 0, "R1", "resume", s3_resume, 0);
    chk(sleep_state == 0, "R1", "state", sleep_state, 0);

    cur_req = "R4";
    wr(A_LO, 0, 16'h00A5);
    expect_out("R2", 16'h00A1, 0, 0);
    wr(A_LO, 0, 16'hFF34);
    expect_out("R4", 16'h0030, 0, 0);

    cur_req = "R5";
    wr(A_HI, 0, 16'h000C);
    expect_out("R5", 16'h0C30, 0, 0);
    wr(A_HI, 0, 16'h0034);
    expect_out("R5", 16'h1430, 1, 0);
    chk(s3_resume == 1, "R7", "resume", s3_resume, 1);
    chk(sleep_state == 3, "R7", "state", sleep_state, 3);
    io_addr = A_HI; #1;
    chk(io_rdata == 16'h0014, "R3", "high view", io_rdata, 16'h0014);
    io_addr = A_LO;
    @(negedge clk); #1;
    chk(sys_reset_pulse == 0, "R7", "pulse width", sys_reset_pulse, 0);
    io_addr = 16'h1F47; #1;
    chk(io_rdata == 16'h0, "R2", "foreign read", io_rdata, 0);
    io_addr = A_LO;

    cur_req = "R6";
    wr(A_LO, 1, 16'h1801);
    expect_out("R9", 16'h1801, 0, 0);
    wr(A_LO, 1, 16'h3805);
    expect_out("R8", 16'h1801, 0, 1);
    @(negedge clk); #1;
    chk(shutdown_req == 0, "R8", "pulse width", shutdown_req, 0);
    wr(A_LO, 1, 16'h3C00);
    expect_out("R8", 16'h1C00, 0, 1);
    wr(A_LO, 1, 16'h2400);
    expect_out("R9", 16'h0400, 0, 0);
    wr(A_LO, 1, 16'h3400);
    expect_out("R6", 16'h1400, 1, 0);
    chk(s3_resume == 1, "R7", "resume sticky", s3_resume, 1);

    cur_req = "R10";
    wr(16'h1F46, 1, 16'hFFFF);
    expect_out("R10", 16'h1400, 0, 0);
    wr(16'h1F40, 0, 16'h00FF);
    expect_out("R10", 16'h1400, 0, 0);
    wr(A_HI, 1, 16'hFFFF);
    expect_out("R10", 16'h1400, 0, 0);
    wr(16'h0F44, 1, 16'h3C00);
    expect_out("R10", 16'h1400, 0, 0);

    repeat (3) @(negedge clk);
    #1;
    chk(s3_resume == 1, "R7", "resume held", s3_resume, 1);
    chk(sleep_state == 3, "R7", "state held", sleep_state, 3);
    finish_run();
  end
endmodule